// File: doc/BRIEF.md
# Transmit Descriptor DMA Sequencer

This block is the control core of a descriptor-driven transmit DMA engine. Once started, it loops through four phases. It asks for the next transmit descriptor and checks whether the DMA side owns that descriptor. It requests that the frame data be moved from memory into the transmit FIFO. It waits for the MAC to report that the frame has left the wire. It then asks for the descriptor to be written back as closed. After the close it goes straight back to fetching the next descriptor. The bus master, descriptor store and FIFO sit outside this block. Each of them talks to the sequencer through a level request that stays high until the matching one-cycle done pulse arrives.

The sequencer parks itself in a Suspended state in two cases: the fetched descriptor still belongs to the host, or the FIFO underflows while the frame is being sent. A poll-demand pulse wakes it from Suspended. A stop command brings it to Stopped, but only after the handshake in flight has completed, so no request is ever dropped half-way. The current phase is always visible as a 3-bit code. Two one-cycle event pulses report each entry into Suspended and each finished descriptor close.

Top module: `txdma_seq`

## Requirements
- R1: While reset is asserted and in the first cycle after it, state_o is 3'b000 (Stopped), all three request outputs are low and both event outputs are low.
- R2: In Stopped, a start_i pulse without stop_i moves state_o to 3'b001 (fetching descriptor) on the next clock, with desc_req_o high; start_i in any other state has no effect.
- R3: In fetching (3'b001), desc_done_i with desc_own_i=1 moves to 3'b011 (reading data, rd_req_o high); desc_done_i with desc_own_i=0 moves to 3'b110 (Suspended).
- R4: In reading, rd_done_i moves to 3'b010 (waiting for end of transmission, no request); there, tx_end_i moves to 3'b111 (closing, cls_req_o high).
- R5: In closing, cls_done_i moves back to 3'b001 (not Stopped) and tx_done_o is high for exactly the one cycle after that edge.
- R6: In waiting, underflow_i moves to 3'b110; when underflow_i and tx_end_i arrive together, underflow wins.
- R7: Every entry into 3'b110 raises buf_unavail_o for exactly the one cycle in which state_o first shows 3'b110.
- R8: In Suspended, poll_i moves to 3'b001; poll_i in any other state has no effect.
- R9: A stop_i pulse seen while a request or the end-of-transmission wait is outstanding leaves the state and its request unchanged until the matching done (or tx_end_i/underflow_i) arrives, then moves to 3'b000; a stop arriving in the same cycle as the done has the same effect.
- R10: stop_i in Suspended moves to 3'b000 on the next clock; in Stopped, stop_i keeps the state at 3'b000 even when start_i is high in the same cycle.
- R11: state_o never shows 3'b100 or 3'b101, and at most one of desc_req_o, rd_req_o, cls_req_o is high at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start command pulse |
| stop_i | input | 1 | Stop command pulse |
| poll_i | input | 1 | Poll-demand pulse, resumes from Suspended |
| desc_req_o | output | 1 | Descriptor fetch request |
| desc_done_i | input | 1 | Descriptor fetch completed |
| desc_own_i | input | 1 | Ownership flag of the fetched descriptor, 1 = DMA owns it, valid with desc_done_i |
| rd_req_o | output | 1 | Frame data read request (memory to FIFO) |
| rd_done_i | input | 1 | Frame data read completed |
| tx_end_i | input | 1 | MAC reports end of transmission |
| underflow_i | input | 1 | Transmit FIFO underflow |
| cls_req_o | output | 1 | Descriptor close request |
| cls_done_i | input | 1 | Descriptor close completed |
| state_o | output | 3 | Encoded process state |
| buf_unavail_o | output | 1 | One-cycle pulse on entry into Suspended |
| tx_done_o | output | 1 | One-cycle pulse per completed descriptor close |

## Verification
The hardest situation to reach from the ports is a stop that arrives while a handshake is still outstanding. Here the sequencer must hold its state and its request for several cycles and then go to Stopped, not to the phase the done would normally select. The stimulus reaches this by driving stop_i in fetching, closing and reading. In fetching it leaves a gap of idle cycles before desc_done_i. In closing it sends cls_done_i one cycle later. In reading it sends stop_i and rd_done_i in the same cycle. The same walk sets up the other collision cases: underflow together with tx_end, and stop together with start.

// File: rtl/txdma_pkg.sv
package txdma_pkg;

  localparam int unsigned ST_W = 3;

  typedef enum logic [ST_W-1:0] {
    ST_STOP    = 3'b000,
    ST_FETCH   = 3'b001,
    ST_WAITEND = 3'b010,
    ST_READ    = 3'b011,
    ST_SUSP    = 3'b110,
    ST_CLOSE   = 3'b111
  } txs_e;

  localparam int unsigned EVT_N   = 2;
  localparam int unsigned EVT_BU  = 0;
  localparam int unsigned EVT_TD  = 1;

endpackage

// File: rtl/txdma_stopctl.sv
module txdma_stopctl (
  input  logic clk,
  input  logic rst_n,
  input  logic stop_i,
  input  logic nxt_is_stop,
  output logic stop_eff
);

  logic pend_q;
  logic pend_d;
  logic pend_en;

  always_comb begin
    pend_d  = (stop_i | pend_q) & ~nxt_is_stop;
    pend_en = (pend_d != pend_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pend_q <= 1'b0;
    else if (pend_en) pend_q <= pend_d;
  end

  assign stop_eff = stop_i | pend_q;

  // A pending stop is dropped once Stopped is reached (R9)
  p_pend_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && nxt_is_stop) |=> !pend_q);

endmodule

// File: rtl/txdma_fsm.sv
module txdma_fsm
  import txdma_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_i,
  input  logic            stop_i,
  input  logic            stop_eff,
  input  logic            poll_i,
  input  logic            desc_done_i,
  input  logic            desc_own_i,
  input  logic            rd_done_i,
  input  logic            tx_end_i,
  input  logic            underflow_i,
  input  logic            cls_done_i,
  output logic            desc_req_o,
  output logic            rd_req_o,
  output logic            cls_req_o,
  output logic [ST_W-1:0] state_o,
  output logic            nxt_is_stop,
  output logic            susp_entry,
  output logic            close_fire
);

  txs_e cur_q;
  txs_e nxt;
  logic cur_en;

  always_comb begin
    nxt = cur_q;
    unique case (cur_q)
      ST_STOP: begin
        if (start_i && !stop_i) nxt = ST_FETCH;
      end
      ST_FETCH: begin
        if (desc_done_i) begin
          if (stop_eff)        nxt = ST_STOP;
          else if (desc_own_i) nxt = ST_READ;
          else                 nxt = ST_SUSP;
        end
      end
      ST_READ: begin
        if (rd_done_i) nxt = stop_eff ? ST_STOP : ST_WAITEND;
      end
      ST_WAITEND: begin
        if (underflow_i || tx_end_i) begin
          if (stop_eff)         nxt = ST_STOP;
          else if (underflow_i) nxt = ST_SUSP;
          else                  nxt = ST_CLOSE;
        end
      end
      ST_CLOSE: begin
        if (cls_done_i) nxt = stop_eff ? ST_STOP : ST_FETCH;
      end
      ST_SUSP: begin
        if (stop_eff)    nxt = ST_STOP;
        else if (poll_i) nxt = ST_FETCH;
      end
      default: nxt = ST_STOP;
    endcase
  end

  assign cur_en = (nxt != cur_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cur_q <= ST_STOP;
    else if (cur_en) cur_q <= nxt;
  end

  always_comb begin
    desc_req_o  = (cur_q == ST_FETCH);
    rd_req_o    = (cur_q == ST_READ);
    cls_req_o   = (cur_q == ST_CLOSE);
    nxt_is_stop = (nxt == ST_STOP);
    susp_entry  = (nxt == ST_SUSP) && (cur_q != ST_SUSP);
    close_fire  = (cur_q == ST_CLOSE) && cls_done_i;
  end

  assign state_o = cur_q;

  // Reserved codes never reach the output (R11)
  p_legal_code_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o != 3'b100) && (state_o != 3'b101));

  // Only one handshake outstanding at a time (R11)
  p_one_req_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({desc_req_o, rd_req_o, cls_req_o}));

  // A finished close loops back to fetching (R5)
  p_close_fetch_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_q == ST_CLOSE && cls_done_i && !stop_eff) |=> (cur_q == ST_FETCH));

  // Fetch request is held until its done arrives, stop or not (R9)
  p_fetch_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_q == ST_FETCH && !desc_done_i) |=> (cur_q == ST_FETCH));

  // Underflow during transmission suspends (R6)
  p_unf_susp_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_q == ST_WAITEND && underflow_i && !stop_eff) |=> (cur_q == ST_SUSP));

  // Stop out of Suspended is immediate (R10)
  p_susp_stop_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_q == ST_SUSP && stop_eff) |=> (cur_q == ST_STOP));

endmodule

// File: rtl/txdma_evt.sv
module txdma_evt #(
  parameter int unsigned N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] fire,
  output logic [N-1:0] pulse
);

  for (genvar g = 0; g < N; g++) begin : g_evt
    logic q;
    logic en;

    assign en = (fire[g] != q);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= 1'b0;
      else if (en) q <= fire[g];
    end

    assign pulse[g] = q;

    // Each event lasts a single cycle (R7, R5)
    p_pulse_one_r7: assert property (@(posedge clk) disable iff (!rst_n)
      pulse[g] |=> !pulse[g]);
  end

endmodule

// File: rtl/txdma_seq.sv
module txdma_seq
  import txdma_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_i,
  input  logic            stop_i,
  input  logic            poll_i,
  output logic            desc_req_o,
  input  logic            desc_done_i,
  input  logic            desc_own_i,
  output logic            rd_req_o,
  input  logic            rd_done_i,
  input  logic            tx_end_i,
  input  logic            underflow_i,
  output logic            cls_req_o,
  input  logic            cls_done_i,
  output logic [ST_W-1:0] state_o,
  output logic            buf_unavail_o,
  output logic            tx_done_o
);

  logic             stop_eff;
  logic             nxt_is_stop;
  logic             susp_entry;
  logic             close_fire;
  logic [EVT_N-1:0] evt_fire;
  logic [EVT_N-1:0] evt_pulse;

  txdma_stopctl u_stopctl (
    .clk         (clk),
    .rst_n       (rst_n),
    .stop_i      (stop_i),
    .nxt_is_stop (nxt_is_stop),
    .stop_eff    (stop_eff)
  );

  txdma_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .stop_i      (stop_i),
    .stop_eff    (stop_eff),
    .poll_i      (poll_i),
    .desc_done_i (desc_done_i),
    .desc_own_i  (desc_own_i),
    .rd_done_i   (rd_done_i),
    .tx_end_i    (tx_end_i),
    .underflow_i (underflow_i),
    .cls_done_i  (cls_done_i),
    .desc_req_o  (desc_req_o),
    .rd_req_o    (rd_req_o),
    .cls_req_o   (cls_req_o),
    .state_o     (state_o),
    .nxt_is_stop (nxt_is_stop),
    .susp_entry  (susp_entry),
    .close_fire  (close_fire)
  );

  always_comb begin
    evt_fire         = '0;
    evt_fire[EVT_BU] = susp_entry;
    evt_fire[EVT_TD] = close_fire;
  end

  txdma_evt #(.N(EVT_N)) u_evt (
    .clk   (clk),
    .rst_n (rst_n),
    .fire  (evt_fire),
    .pulse (evt_pulse)
  );

  assign buf_unavail_o = evt_pulse[EVT_BU];
  assign tx_done_o     = evt_pulse[EVT_TD];

  // Suspend event only together with the first Suspended cycle (R7)
  p_bu_entry_r7: assert property (@(posedge clk) disable iff (!rst_n)
    buf_unavail_o |-> (state_o == 3'b110) && ($past(state_o) != 3'b110));

  // Done event only after leaving closing (R5)
  p_td_close_r5: assert property (@(posedge clk) disable iff (!rst_n)
    tx_done_o |-> ($past(state_o) == 3'b111));

endmodule

// File: tb/txdma_seq_bench.sv
module txdma_seq_bench;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       start_i, stop_i, poll_i;
  logic       desc_done_i, desc_own_i, rd_done_i;
  logic       tx_end_i, underflow_i, cls_done_i;
  logic       desc_req_o, rd_req_o, cls_req_o;
  logic [2:0] state_o;
  logic       buf_unavail_o, tx_done_o;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  txdma_seq u_txdma_seq (
    .clk           (clk),
    .rst_n         (rst_n),
    .start_i       (start_i),
    .stop_i        (stop_i),
    .poll_i        (poll_i),
    .desc_req_o    (desc_req_o),
    .desc_done_i   (desc_done_i),
    .desc_own_i    (desc_own_i),
    .rd_req_o      (rd_req_o),
    .rd_done_i     (rd_done_i),
    .tx_end_i      (tx_end_i),
    .underflow_i   (underflow_i),
    .cls_req_o     (cls_req_o),
    .cls_done_i    (cls_done_i),
    .state_o       (state_o),
    .buf_unavail_o (buf_unavail_o),
    .tx_done_o     (tx_done_o)
  );

  // Vector: [16:8] start,stop,poll,desc_done,own,rd_done,underflow,tx_end,cls_done
  //         [7:5] expected state, [4] buf_unavail, [3] tx_done, [2:0] desc,rd,cls req
  localparam int NV = 34;
  localparam logic [16:0] VEC [NV] = '{
    17'b000000000_000_0_0_000, //  0 idle in Stopped            R1
    17'b001000000_000_0_0_000, //  1 poll ignored in Stopped    R8
    17'b100000000_001_0_0_100, //  2 start -> fetch             R2
    17'b100000000_001_0_0_100, //  3 start ignored in fetch     R2
    17'b000110000_011_0_0_010, //  4 owned desc -> read         R3
    17'b000000000_011_0_0_010, //  5 hold read                  R4
    17'b000001000_010_0_0_000, //  6 read done -> wait          R4
    17'b000000010_111_0_0_001, //  7 tx end -> close            R4
    17'b000000001_001_0_1_100, //  8 close done -> fetch        R5
    17'b000000000_001_0_0_100, //  9 done pulse is one cycle    R5
    17'b000100000_110_1_0_000, // 10 host-owned -> suspended    R3 R7
    17'b000000000_110_0_0_000, // 11 unavail pulse one cycle    R7
    17'b001000000_001_0_0_100, // 12 poll -> fetch              R8
    17'b000110000_011_0_0_010, // 13                            R3
    17'b000001000_010_0_0_000, // 14                            R4
    17'b000000110_110_1_0_000, // 15 underflow beats tx end     R6 R7
    17'b001000000_001_0_0_100, // 16 poll -> fetch              R8
    17'b010000000_001_0_0_100, // 17 stop, fetch outstanding    R9
    17'b000000000_001_0_0_100, // 18 still fetching             R9
    17'b000110000_000_0_0_000, // 19 done -> Stopped            R9
    17'b110000000_000_0_0_000, // 20 stop beats start           R10
    17'b100000000_001_0_0_100, // 21                            R2
    17'b000100000_110_1_0_000, // 22                            R3 R7
    17'b010000000_000_0_0_000, // 23 stop in suspended          R10
    17'b100000000_001_0_0_100, // 24                            R2
    17'b000110000_011_0_0_010, // 25                            R3
    17'b000001000_010_0_0_000, // 26                            R4
    17'b000000010_111_0_0_001, // 27                            R4
    17'b010000000_111_0_0_001, // 28 stop, close outstanding    R9
    17'b000000001_000_0_1_000, // 29 close done -> Stopped      R9 R5
    17'b000000000_000_0_0_000, // 30                            R9
    17'b100000000_001_0_0_100, // 31                            R2
    17'b000110000_011_0_0_010, // 32                            R3
    17'b010001000_000_0_0_000  // 33 stop with read done        R9
  };
  localparam int VREQ [NV] = '{1,8,2,2,3,4,4,4,5,5,3,7,8,3,4,6,8,9,9,9,
                               10,2,3,10,2,3,4,4,9,9,9,2,3,9};

  task automatic set_in(input logic [8:0] v);
    {start_i, stop_i, poll_i, desc_done_i, desc_own_i,
     rd_done_i, underflow_i, tx_end_i, cls_done_i} = v;
  endtask

  task automatic check(input int rq, input logic [7:0] exp, input string what);
    logic [7:0] act;
    act = {state_o, buf_unavail_o, tx_done_o, desc_req_o, rd_req_o, cls_req_o};
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL R%0d %s: actual %b expected %b", rq, what, act, exp);
    end
    // R11: reserved codes never observed
    n_chk++;
    if (state_o === 3'b100 || state_o === 3'b101) begin
      n_fail++;
      $display("FAIL R11 reserved state: actual %b expected not 10x", state_o);
    end
  endtask

  task automatic finish_run;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    rst_n = 1'b0;
    set_in('0);
    #1;
    check(1, 8'b000_0_0_000, "state during reset");       // R1
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    @(posedge clk); #1;
    check(1, 8'b000_0_0_000, "first cycle after reset");  // R1

    for (int i = 0; i < NV; i++) begin
      @(negedge clk) set_in(VEC[i][16:8]);
      @(posedge clk); #1;
      check(VREQ[i], VEC[i][7:0], $sformatf("vector %0d", i));
    end
    @(negedge clk) set_in('0);

    // R1: reset in the middle of a transfer returns to Stopped at once
    @(negedge clk) set_in(9'b100000000);
    @(posedge clk); #1;
    check(2, 8'b001_0_0_100, "start before mid-run reset");
    @(negedge clk) begin set_in('0); rst_n = 1'b0; end
    #1;
    check(1, 8'b000_0_0_000, "mid-run reset");
    @(negedge clk) rst_n = 1'b1;

    // R9: stop in the end-of-transmission wait takes effect at tx end
    @(negedge clk) set_in(9'b100000000);
    @(negedge clk) set_in(9'b000110000);
    @(negedge clk) set_in(9'b000001000);
    @(negedge clk) set_in(9'b010000000);
    @(posedge clk); #1;
    check(9, 8'b010_0_0_000, "stop held in wait");
    @(negedge clk) set_in(9'b000000010);
    @(posedge clk); #1;
    check(9, 8'b000_0_0_000, "tx end with stop pending");
    @(negedge clk) set_in('0);

    done = 1'b1;
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

endmodule